// File: doc/BRIEF.md
# Segment-Mapped Address Translator

This block is the first stage of address translation for a processor memory port. Each request carries a 32-bit virtual address, a flag that marks user-mode accesses and a two-bit access kind. From these the block either resolves the access on the spot or hands it to the page lookup stage that follows it.

A request is resolved on the spot in two cases. When translation is switched off, the address passes through unchanged. When a kernel-mode access falls in a segment configured for direct mapping, the top four address bits are replaced by a base nibble taken from one of two packed base registers. Every other access goes to the page lookup stage with its virtual address intact.

A small write port loads four configuration registers: a control word holding the two enable bits, a 16-bit segment mapping mask, and a low and a high base register. Results leave through a single register stage with a valid/ready handshake toward the page lookup stage.

Top module: `seg_xlate_front`

## Requirements
- R1: While `rst_n` is low at a clock edge, all configuration registers clear to zero and `out_valid` drops to 0. After reset, translation is therefore off and requests pass through.
- R2: Translation is on when bit 2 or bit 3 of the control word is 1. Setting only bits 0 and 1 leaves it off. While it is off, `out_addr` equals the virtual address, `out_final` is 1 and `out_perm` is 3'b111.
- R3: The segment number is virtual address bits 31:28. A segment is direct-mapped when the bit of the mapping mask at the segment number is 1.
- R4: A user-mode access (`req_user`=1) is always forwarded while translation is on: `out_final`=0, `out_perm`=3'b000 and `out_addr` equals the virtual address, whatever the mask holds.
- R5: Segments 0 to 7 take their nibble from the low base register and segments 8 to 15 from the high one. The nibble sits at bit offset 4*(segment mod 8).
- R6: A mapped kernel access yields `out_addr` = {nibble, vaddr[27:0]}, `out_final`=1 and `out_perm`=3'b111. The permission bits are bit0 read, bit1 write and bit2 execute.
- R7: A kernel access to a segment whose mask bit is 0 is forwarded while translation is on: `out_final`=0, `out_perm`=3'b000 and `out_addr` equals the virtual address.
- R8: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. Its result is valid after that edge. `req_ready` = !`out_valid` || `out_ready`. While `out_valid`=1 and `out_ready`=0, every output field holds steady.
- R9: `out_user` and `out_kind` repeat the accepted request's mode flag and access kind.
- R10: A write with `cfg_wr_en`=1 loads the register picked by `cfg_wr_sel`: 0 control word, 1 mapping mask (data bits 15:0), 2 low base, 3 high base. The write governs every request accepted on a later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 2 | Configuration register select |
| cfg_wr_data | input | 32 | Configuration write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_vaddr | input | 32 | Virtual address |
| req_user | input | 1 | 1 = user-mode access |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts result |
| out_addr | output | 32 | Physical address, or virtual address when forwarded |
| out_final | output | 1 | 1 = resolved here, 0 = page lookup needed |
| out_perm | output | 3 | Granted permissions {exec, write, read} |
| out_user | output | 1 | Mode flag of the request |
| out_kind | output | 2 | Access kind of the request |

## Verification
The bench builds the block with its default values: a 32-bit address, 4 segment bits and enable bits 2 and 3. These values bring all sixteen segment nibble slots within reach. The bench maps the boundary segments 0, 7, 8 and 15 and one middle segment, so the crossover between the low and high base registers and both ends of each register are exercised. A pseudo-random `out_ready` pattern creates stalls of varying length, which tests the hold-steady and ready rules against a scoreboard of expected results.

// File: rtl/xlate_pkg.sv
// Shared constants for the segment translator.
// Assumes a 3-bit permission field ordered {exec, write, read}.
package xlate_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_BASEL = 2'd2,
        SEL_BASEH = 2'd3
    } cfg_sel_e;

    localparam logic [2:0] PERM_ALL  = 3'b111;
    localparam logic [2:0] PERM_NONE = 3'b000;
endpackage

// File: rtl/xlate_cfg_regs.sv
// Configuration registers of the translator: the two enable bits, the
// segment mapping mask and the two packed base registers.
// Assumes DATA_W >= NSEG, DATA_W >= BASE_W and both enable bit positions < DATA_W.
module xlate_cfg_regs
    import xlate_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NSEG   = 16,
    parameter int BASE_W = 32,
    parameter int EN_A   = 2,
    parameter int EN_B   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [1:0]        en_bits,
    output logic [NSEG-1:0]   seg_mask,
    output logic [BASE_W-1:0] base_lo,
    output logic [BASE_W-1:0] base_hi
);
    // Load the selected register; reset clears everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_bits  <= '0;
            seg_mask <= '0;
            base_lo  <= '0;
            base_hi  <= '0;
        end else if (wr_en) begin
            case (cfg_sel_e'(wr_sel))
                SEL_CTRL:  en_bits  <= {wr_data[EN_B], wr_data[EN_A]};
                SEL_MASK:  seg_mask <= wr_data[NSEG-1:0];
                SEL_BASEL: base_lo  <= wr_data[BASE_W-1:0];
                default:   base_hi  <= wr_data[BASE_W-1:0];
            endcase
        end
    end

    // R1
    cfg_reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (en_bits == '0 && seg_mask == '0 && base_lo == '0 && base_hi == '0));

    // R10
    cfg_mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_MASK) |=> seg_mask == $past(wr_data[NSEG-1:0]));
endmodule

// File: rtl/xlate_seg_map.sv
// Combinational resolution of one request. It either passes the address
// through, remaps the top segment bits, or marks the request for page lookup.
// Assumes 2*BASE_W covers one nibble slot per segment.
module xlate_seg_map
    import xlate_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int SEG_BITS = 4
) (
    input  logic [ADDR_W-1:0]                      vaddr,
    input  logic                                   user,
    input  logic [1:0]                             en_bits,
    input  logic [(1<<SEG_BITS)-1:0]               seg_mask,
    input  logic [((1<<SEG_BITS)/2)*SEG_BITS-1:0]  base_lo,
    input  logic [((1<<SEG_BITS)/2)*SEG_BITS-1:0]  base_hi,
    output logic [ADDR_W-1:0]                      paddr,
    output logic                                   fin,
    output logic [2:0]                             perm
);
    localparam int NSEG = 1 << SEG_BITS;
    localparam int HALF = NSEG / 2;
    localparam int LOW_W = ADDR_W - SEG_BITS;

    logic [SEG_BITS-1:0] seg_nib [NSEG];
    logic [SEG_BITS-1:0] seg;
    logic                xlate_on;
    logic                direct;

    // One nibble slot per segment: the low half from base_lo, the upper half from base_hi.
    for (genvar g = 0; g < NSEG; g++) begin : g_nib
        if (g < HALF) begin : g_lo
            assign seg_nib[g] = base_lo[g*SEG_BITS +: SEG_BITS];
        end else begin : g_hi
            assign seg_nib[g] = base_hi[(g-HALF)*SEG_BITS +: SEG_BITS];
        end
    end

    assign seg      = vaddr[ADDR_W-1 -: SEG_BITS];
    assign xlate_on = |en_bits;
    assign direct   = !user && seg_mask[seg];

    // Pick pass-through, remap or forward.
    always_comb begin
        paddr = vaddr;
        fin   = 1'b1;
        perm  = PERM_ALL;
        if (xlate_on) begin
            if (direct) begin
                paddr = {seg_nib[seg], vaddr[LOW_W-1:0]};
            end else begin
                fin  = 1'b0;
                perm = PERM_NONE;
            end
        end
    end
endmodule

// File: rtl/xlate_out_stage.sv
// Single register stage with a valid/ready handshake toward the page lookup stage.
// Assumes the upstream holds its request until it is accepted.
module xlate_out_stage #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_fin,
    input  logic [2:0]        in_perm,
    input  logic              in_user,
    input  logic [1:0]        in_kind,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_fin,
    output logic [2:0]        out_perm,
    output logic              out_user,
    output logic [1:0]        out_kind
);
    logic take;

    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    // Valid flag: set on accept, cleared when drained without a refill.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else if (in_ready)
            out_valid <= in_valid;
    end

    // Payload: captured only on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_addr <= '0;
            out_fin  <= 1'b0;
            out_perm <= '0;
            out_user <= 1'b0;
            out_kind <= '0;
        end else if (take) begin
            out_addr <= in_addr;
            out_fin  <= in_fin;
            out_perm <= in_perm;
            out_user <= in_user;
            out_kind <= in_kind;
        end
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_fin)
                                      && $stable(out_perm) && $stable(out_kind)));

    // R8
    accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);
endmodule

// File: rtl/seg_xlate_front.sv
// Front-end address translator. Resolves pass-through and directly mapped
// kernel segments; everything else is flagged for the page lookup stage.
// Assumes configuration writes and requests come from the same clock domain.
module seg_xlate_front
    import xlate_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int SEG_BITS = 4,
    parameter int EN_A     = 2,
    parameter int EN_B     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_wr_sel,
    input  logic [ADDR_W-1:0] cfg_wr_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_user,
    input  logic [1:0]        req_kind,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_final,
    output logic [2:0]        out_perm,
    output logic              out_user,
    output logic [1:0]        out_kind
);
    localparam int NSEG   = 1 << SEG_BITS;
    localparam int BASE_W = (NSEG / 2) * SEG_BITS;

    logic [1:0]        en_bits;
    logic [NSEG-1:0]   seg_mask;
    logic [BASE_W-1:0] base_lo;
    logic [BASE_W-1:0] base_hi;
    logic [ADDR_W-1:0] map_addr;
    logic              map_fin;
    logic [2:0]        map_perm;

    xlate_cfg_regs #(
        .DATA_W(ADDR_W), .NSEG(NSEG), .BASE_W(BASE_W), .EN_A(EN_A), .EN_B(EN_B)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel), .wr_data(cfg_wr_data),
        .en_bits(en_bits), .seg_mask(seg_mask), .base_lo(base_lo), .base_hi(base_hi)
    );

    xlate_seg_map #(.ADDR_W(ADDR_W), .SEG_BITS(SEG_BITS)) u_map (
        .vaddr(req_vaddr), .user(req_user), .en_bits(en_bits), .seg_mask(seg_mask),
        .base_lo(base_lo), .base_hi(base_hi),
        .paddr(map_addr), .fin(map_fin), .perm(map_perm)
    );

    xlate_out_stage #(.ADDR_W(ADDR_W)) u_out (
        .clk(clk), .rst_n(rst_n),
        .in_valid(req_valid), .in_ready(req_ready),
        .in_addr(map_addr), .in_fin(map_fin), .in_perm(map_perm),
        .in_user(req_user), .in_kind(req_kind),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_fin(out_final), .out_perm(out_perm),
        .out_user(out_user), .out_kind(out_kind)
    );

    // R4
    user_never_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_user && |en_bits && !$past(cfg_wr_en)) |-> !out_final);

    // R6
    final_full_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_final) |-> out_perm == PERM_ALL);

    // R7
    forward_no_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_final) |-> out_perm == PERM_NONE);
endmodule

// File: tb/seg_xlate_front_tb.sv
module seg_xlate_front_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_wr_sel = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_user = 1'b0;
    logic [1:0]  req_kind = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_addr;
    logic        out_final;
    logic [2:0]  out_perm;
    logic        out_user;
    logic [1:0]  out_kind;

    always #4 clk = ~clk;

    seg_xlate_front u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_user(req_user), .req_kind(req_kind),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_final(out_final), .out_perm(out_perm), .out_user(out_user), .out_kind(out_kind)
    );

    int total = 0;
    int bad = 0;
    logic [31:0] m_ctrl = '0, m_mask = '0, m_lo = '0, m_hi = '0;
    logic [38:0] exp_q [$];
    string       tag_q [$];
    logic        stall_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic        held = 1'b0;
    logic [38:0] held_v = '0;

    task automatic chk(input bit ok, input string tag, input logic [38:0] act, input logic [38:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [38:0] model(input logic [31:0] va, input logic usr, input logic [1:0] k);
        logic [3:0] s;
        logic [3:0] nib;
        s = va[31:28];
        if (!(m_ctrl[2] | m_ctrl[3])) return {va, 1'b1, 3'b111, usr, k};
        if (!usr && m_mask[s]) begin
            nib = (s < 8) ? m_lo[4*s +: 4] : m_hi[4*(s-8) +: 4];
            return {nib, va[27:0], 1'b1, 3'b111, usr, k};
        end
        return {va, 1'b0, 3'b000, usr, k};
    endfunction

    task automatic wcfg(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
        @(posedge clk);
        case (sel)
            2'd0: m_ctrl = d;
            2'd1: m_mask = {16'h0, d[15:0]};
            2'd2: m_lo = d;
            default: m_hi = d;
        endcase
        #1 cfg_wr_en = 1'b0;
    endtask

    task automatic send(input logic [31:0] va, input logic usr, input logic [1:0] k, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_user = usr; req_kind = k;
        #1;
        while (!req_ready) begin
            @(negedge clk); #1;
        end
        @(posedge clk);
        exp_q.push_back(model(va, usr, k));
        tag_q.push_back(tag);
        #1 req_valid = 1'b0;
        @(negedge clk); #1;
        chk(out_valid === 1'b1, "R8 latency", {38'h0, out_valid}, 39'h1);
    endtask

    // Downstream ready pattern.
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = stall_en ? lfsr[0] : 1'b1;
    end

    // Monitor: compare results and stall stability.
    always @(negedge clk) begin
        #2;
        if (rst_n && out_valid) begin
            if (held)
                chk({out_addr, out_final, out_perm, out_user, out_kind} === held_v, "R8 hold",
                    {out_addr, out_final, out_perm, out_user, out_kind}, held_v);
            if (out_ready) begin
                held = 1'b0;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected result", {out_addr, out_final, out_perm, out_user, out_kind}, '0);
                end else begin
                    logic [38:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({out_addr, out_final, out_perm, out_user, out_kind} === e, t,
                        {out_addr, out_final, out_perm, out_user, out_kind}, e);
                end
            end else begin
                held = 1'b1;
                held_v = {out_addr, out_final, out_perm, out_user, out_kind};
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0, "R1 valid after reset", {38'h0, out_valid}, 39'h0);
        chk(req_ready === 1'b1, "R8 ready idle", {38'h0, req_ready}, 39'h1);
        send(32'h3123_4567, 1'b0, 2'd0, "R1 passthrough after reset");
        // R2: low control bits do not enable
        wcfg(2'd1, 32'h0000_FFFF);
        wcfg(2'd2, 32'h89AB_CDEF);
        wcfg(2'd3, 32'h1357_9BDF);
        wcfg(2'd0, 32'h0000_0003);
        send(32'h0ABC_DEF0, 1'b0, 2'd1, "R2 bits0-1 off");
        send(32'hF000_0010, 1'b1, 2'd2, "R2 off user");
        // R10 enable via bit 2, narrow mask
        wcfg(2'd0, 32'h0000_0004);
        wcfg(2'd1, 32'hFFFF_8189);
        send(32'h0111_2222, 1'b0, 2'd0, "R5 seg0 low base");
        send(32'h3FFF_FFFF, 1'b0, 2'd1, "R6 seg3 remap");
        send(32'h7000_0001, 1'b0, 2'd2, "R5 seg7 top of low");
        send(32'h8765_4321, 1'b0, 2'd0, "R5 seg8 high base");
        send(32'hFEDC_BA98, 1'b0, 2'd2, "R5 seg15 top of high");
        send(32'h5555_5555, 1'b0, 2'd0, "R7 kernel unmapped");
        send(32'h3FFF_FFFF, 1'b1, 2'd1, "R4 user mapped seg");
        send(32'h8000_0000, 1'b1, 2'd2, "R9 user kind fetch");
        // R2 enable via bit 3 only
        wcfg(2'd0, 32'h0000_0008);
        send(32'hF123_0000, 1'b0, 2'd1, "R2 bit3 enable");
        // R10 mask change applies to the next request
        wcfg(2'd1, 32'h0000_0020);
        send(32'h5000_0ABC, 1'b0, 2'd0, "R10 new mask seg5");
        send(32'h0000_0ABC, 1'b0, 2'd0, "R3 seg0 cleared");
        wcfg(2'd3, 32'hA000_0000);
        wcfg(2'd1, 32'h0000_8000);
        send(32'hF0F0_F0F0, 1'b0, 2'd1, "R10 new high base");
        // R8 stalls
        stall_en = 1'b1;
        for (int i = 0; i < 40; i++)
            send({i[3:0], 28'h0ACE_001} ^ {4'h0, i[27:0]}, i[0], i[2:1] == 2'd3 ? 2'd0 : i[2:1], "R8 stalled stream");
        wait (exp_q.size() == 0);
        stall_en = 1'b0;
        repeat (4) @(posedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule